// File: doc/BRIEF.md
# Programmable Clock Post-Divider with Glitch-Free Output Gating

This block sits after a clock source and scales it down by a selectable ratio. The ratio is picked with a 3-bit code from a fixed table. For every ratio of 2 or more the output is square, with a 50% duty cycle. One code setting passes the source clock straight through. The result fans out to six channels. Each channel has a true output and an inverted output.

An output-enable input is retimed inside the block. A change in the enable therefore reaches the outputs only while the source clock is low, so turning the outputs on or off never produces a runt pulse. When the outputs are disabled or held in reset, every true output sits low and every inverted output sits high. A new ratio code is adopted only at the moment the divided output falls. The high phase already in progress is therefore never cut short.

The ratio engine is a three-state machine:
- `ST_LOW` counts the low half-period. When the count reaches the half value (*half-done*), it moves to `ST_HIGH`.
- `ST_HIGH` counts the high half-period. At *fall* it returns to `ST_LOW` and loads the new half value. If the new code is the pass-through code, it moves to `ST_BYPASS` instead (*enter-bypass*).
- `ST_BYPASS` passes the clock through. When the code leaves pass-through (*leave-bypass*), it moves to `ST_LOW` with the new half value.

Top module: `vco_post_divider`

## Requirements
- R1: Codes 3'b000, 3'b001, 3'b010 and 3'b011 divide the clock by 2, 4, 8 and 16.
- R2: Codes 3'b101, 3'b110 and 3'b111 divide by 2, 4 and 8. Code 3'b100 divides by 1: the true output is high during the clock's high half and low during its low half.
- R3: For a ratio R of 2 or more, the true output stays high for R/2 clock cycles and then low for R/2 cycles. It changes only on a rising clock edge.
- R4: While the outputs are disabled, every true output is 0 and every inverted output is 1.
- R5: A change of the enable input made just after rising edge k has no effect through rising edge k+1. It takes effect at the falling edge that follows rising edge k+1.
- R6: Master reset high forces every true output to 0 and every inverted output to 1 at once, without waiting for a clock. Releasing reset with the enable high turns the outputs back on with no other action.
- R7: After reset the ratio is 2. The first divided period after reset is 2 cycles long, whatever code is applied.
- R8: A change of code while the output is high takes effect only when the output falls. The high phase in progress keeps its full length, and the new ratio starts with the next low phase.
- R9: All six channels carry identical true outputs, and each inverted output is the exact complement of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Source clock to be divided |
| rst | input | 1 | Master reset, active high, asynchronous |
| n_code | input | 3 | Ratio select code |
| out_en | input | 1 | Output enable, active high |
| ch_true | output | 6 | True clock outputs, one per channel |
| ch_comp | output | 6 | Inverted clock outputs, one per channel |

## Verification
Two events can fall in the same cycle:
- **Code change during the high phase.** A new code can arrive while a high phase is running. The bench changes the code from divide-by-16 to divide-by-2 three cycles into a high phase. It then judges the outcome from the length of that high run, which must stay 8 cycles. It also checks the 1-cycle low and high runs that follow.
- **Enable change during the pass-through high half.** The enable can drop while the clock is passing through and is in its high half. The bench drops the enable just after a rising edge in pass-through mode. It expects the next high half to remain intact and the output to be forced off from the falling edge after it.

A full sweep of all eight codes compares the sampled waveform, at both clock phases, against the ratio the bench computes arithmetically from the code.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

    localparam int CODE_W = 3;
    localparam int HALF_W = 4;

    typedef enum logic [1:0] {
        ST_LOW    = 2'd0,
        ST_HIGH   = 2'd1,
        ST_BYPASS = 2'd2
    } div_state_t;

    // Pass-through code: clock forwarded without division.
    localparam logic [CODE_W-1:0] CODE_BYPASS = 3'b100;

    // Half-period length, in source cycles, for a non-bypass code.
    // Codes with the top bit clear give 1,2,4,8; with the top bit set they
    // give 1,2,4 (code 3'b100 is pass-through and never reaches here).
    function automatic logic [HALF_W-1:0] code_to_half(input logic [CODE_W-1:0] c);
        logic [1:0] sh;
        if (c[CODE_W-1] == 1'b0) begin
            sh = c[1:0];
        end else begin
            sh = c[1:0] - 2'd1;
        end
        return HALF_W'(1) << sh;
    endfunction

endpackage

// File: rtl/vpd_enable_sync.sv
module vpd_enable_sync (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    output logic gate
);

    logic en_rise;   // first stage, rising edge
    logic en_fall;   // second stage, falling edge

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            en_rise <= 1'b0;
        end else begin
            en_rise <= en_in;
        end
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            en_fall <= 1'b0;
        end else begin
            en_fall <= en_rise;
        end
    end

    assign gate = en_fall;

    // R5: by every rising edge the falling stage has caught up with the rising stage
    a_r5_en_order: assert property (@(posedge clk) disable iff (rst)
        en_fall == en_rise);

endmodule

// File: rtl/vpd_div_fsm.sv
module vpd_div_fsm
    import vpd_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] n_code,
    output logic          div_hi,
    output logic          in_bypass
);

    localparam logic [HW-1:0] HALF_RESET = HW'(1);   // divide-by-2 after reset

    div_state_t    state, state_nx;
    logic [HW-1:0] cnt, cnt_nx;
    logic [HW-1:0] half_r, half_nx;
    logic          code_byp;
    logic [HW-1:0] code_half;

    always_comb begin
        code_byp  = (n_code == CW'(CODE_BYPASS));
        code_half = code_to_half(n_code);
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state  <= ST_LOW;
            cnt    <= '0;
            half_r <= HALF_RESET;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            half_r <= half_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        cnt_nx    = cnt;
        half_nx   = half_r;
        div_hi    = 1'b0;
        in_bypass = 1'b0;
        unique case (state)
            ST_LOW: begin
                if (cnt == half_r - HW'(1)) begin        // half-done
                    state_nx = ST_HIGH;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + HW'(1);
                end
            end
            ST_HIGH: begin
                div_hi = 1'b1;
                if (cnt == half_r - HW'(1)) begin
                    cnt_nx = '0;
                    if (code_byp) begin                   // enter-bypass
                        state_nx = ST_BYPASS;
                    end else begin                        // fall
                        state_nx = ST_LOW;
                        half_nx  = code_half;
                    end
                end else begin
                    cnt_nx = cnt + HW'(1);
                end
            end
            ST_BYPASS: begin
                in_bypass = 1'b1;
                if (!code_byp) begin                      // leave-bypass
                    state_nx = ST_LOW;
                    cnt_nx   = '0;
                    half_nx  = code_half;
                end
            end
            default: begin
                state_nx = ST_LOW;
                cnt_nx   = '0;
            end
        endcase
    end

    // R8: the ratio only moves when a high phase ends or pass-through is left
    a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
        (!($past(state) == ST_HIGH && state != ST_HIGH) && $past(state) != ST_BYPASS)
        |-> $stable(half_r));

    // R3: a half-period counter never runs past its half value
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        (state != ST_BYPASS) |-> (cnt < half_r));

endmodule

// File: rtl/vpd_out_drive.sv
module vpd_out_drive #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate,
    input  logic              div_hi,
    input  logic              in_bypass,
    output logic [NUM_CH-1:0] out_true,
    output logic [NUM_CH-1:0] out_comp
);

    logic sel_byp;   // source selection, retimed to the falling edge
    logic pre;

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            sel_byp <= 1'b0;
        end else begin
            sel_byp <= in_bypass;
        end
    end

    always_comb begin
        pre = gate & (sel_byp ? clk : div_hi);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign out_true[g] = pre;
        assign out_comp[g] = ~pre;
    end

    // R4: a closed gate keeps every true output low at each rising edge
    a_r4_gate_low: assert property (@(posedge clk) disable iff (rst)
        !gate |-> (out_true == '0));

endmodule

// File: rtl/vco_post_divider.sv
module vco_post_divider
    import vpd_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk_vco,
    input  logic              rst,
    input  logic [2:0]        n_code,
    input  logic              out_en,
    output logic [NUM_CH-1:0] ch_true,
    output logic [NUM_CH-1:0] ch_comp
);

    logic gate;
    logic div_hi;
    logic in_bypass;

    vpd_enable_sync u_en (
        .clk   (clk_vco),
        .rst   (rst),
        .en_in (out_en),
        .gate  (gate)
    );

    vpd_div_fsm #(.CW(CODE_W), .HW(HALF_W)) u_fsm (
        .clk       (clk_vco),
        .rst       (rst),
        .n_code    (n_code),
        .div_hi    (div_hi),
        .in_bypass (in_bypass)
    );

    vpd_out_drive #(.NUM_CH(NUM_CH)) u_drv (
        .clk       (clk_vco),
        .rst       (rst),
        .gate      (gate),
        .div_hi    (div_hi),
        .in_bypass (in_bypass),
        .out_true  (ch_true),
        .out_comp  (ch_comp)
    );

    // R6: reset holds fixed complementary levels
    a_r6_reset_levels: assert property (@(negedge clk_vco)
        rst |-> (ch_true == '0 && ch_comp == '1));

endmodule

// File: tb/vco_post_divider_test.sv
module vco_post_divider_test;

    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b0;
    logic [2:0]     n_code = 3'b000;
    logic           out_en = 1'b1;
    logic [NCH-1:0] ch_true;
    logic [NCH-1:0] ch_comp;

    int total = 0;
    int bad = 0;
    int chan_err = 0;
    bit done = 0;

    vco_post_divider #(.NUM_CH(NCH)) uut (
        .clk_vco (clk),
        .rst     (rst),
        .n_code  (n_code),
        .out_en  (out_en),
        .ch_true (ch_true),
        .ch_comp (ch_comp)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R9 is tracked on every sample
    task automatic smp(output logic v);
        v = ch_true[0];
        if (ch_true != {NCH{v}} || ch_comp != ~ch_true) chan_err++;
    endtask

    task automatic at_pos(output logic v);
        @(posedge clk); #2;
        smp(v);
    endtask

    task automatic at_neg(output logic v);
        @(negedge clk); #2;
        smp(v);
    endtask

    function automatic int ratio_of(input int c);
        if (c < 4) return 2 << c;
        if (c == 4) return 1;
        return 1 << (c - 4);
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic v;
        logic ps [0:63];
        logic ns [0:63];
        int errs;
        int first;
        int run;

        // ---- reset state, R6
        #1 rst = 1'b1;
        n_code = 3'b011;
        #1;
        chk(ch_true == '0 && ch_comp == '1, "R6 async reset levels", int'(ch_true), 0);
        errs = 0;
        for (int i = 0; i < 4; i++) begin
            at_pos(v); if (v !== 1'b0) errs++;
            at_neg(v); if (v !== 1'b0 || ch_comp !== '1) errs++;
        end
        chk(errs == 0, "R6 held during reset", errs, 0);

        // ---- release: first period is divide-by-2, R7
        rst = 1'b0;
        at_pos(v); chk(v == 1'b0, "R7 gate closed at first edge", v, 0);
        at_neg(v); chk(v == 1'b1, "R7 first high half", v, 1);
        at_pos(v); chk(v == 1'b0, "R7 first period ends after 2", v, 0);
        at_pos(v); chk(v == 1'b0, "R7 new ratio low phase", v, 0);

        // ---- sweep all codes, R1 R2 R3
        for (int c = 0; c < 8; c++) begin
            int r;
            int h;
            n_code = 3'(c);
            r = ratio_of(c);
            h = r / 2;
            repeat (40) @(posedge clk);
            for (int i = 0; i < 64; i++) begin
                at_pos(ps[i]);
                at_neg(ns[i]);
            end
            errs = 0;
            if (r == 1) begin
                for (int i = 0; i < 64; i++) begin
                    if (ps[i] !== 1'b1 || ns[i] !== 1'b0) errs++;
                end
                chk(errs == 0, $sformatf("R2 pass-through code %0d", c), errs, 0);
            end else begin
                first = -1;
                for (int i = 1; i < 20; i++) begin
                    if (first < 0 && ps[i-1] == 1'b0 && ps[i] == 1'b1) first = i;
                end
                if (first < 0) begin
                    errs = 99;
                end else begin
                    for (int j = 0; j < 2 * r; j++) begin
                        if (ps[first+j] !== ((j % r) < h)) errs++;
                        if (ns[first+j] !== ps[first+j]) errs++;
                    end
                end
                chk(errs == 0, $sformatf("%s R3 code %0d ratio %0d",
                    (c < 4) ? "R1" : "R2", c, r), errs, 0);
            end
        end

        // ---- code change during a high phase, R8
        n_code = 3'b011;
        repeat (40) @(posedge clk);
        at_pos(v);
        begin
            logic prev;
            prev = v;
            for (int i = 0; i < 40; i++) begin
                at_pos(v);
                if (prev == 1'b0 && v == 1'b1) break;
                prev = v;
            end
        end
        run = 1;
        at_pos(v); run += v;
        at_pos(v); run += v;
        n_code = 3'b000;
        for (int i = 0; i < 20; i++) begin
            at_pos(v);
            if (v == 1'b0) break;
            run++;
        end
        chk(run == 8, "R8 high phase kept full length", run, 8);
        at_pos(v); chk(v == 1'b1, "R8 new ratio high", v, 1);
        at_pos(v); chk(v == 1'b0, "R8 new ratio low", v, 0);

        // ---- enable timing in pass-through mode, R5 R4
        n_code = 3'b100;
        repeat (40) @(posedge clk);
        at_pos(v);
        out_en = 1'b0;
        at_pos(v); chk(v == 1'b1, "R5 disable not applied yet", v, 1);
        at_neg(v); chk(ch_comp == '1, "R4 complement high when off", int'(ch_comp), 63);
        errs = 0;
        for (int i = 0; i < 6; i++) begin
            at_pos(v); if (v !== 1'b0 || ch_comp !== '1) errs++;
        end
        chk(errs == 0, "R4 R5 outputs forced off", errs, 0);
        out_en = 1'b1;
        at_pos(v); chk(v == 1'b0, "R5 enable not applied yet", v, 0);
        at_pos(v); chk(v == 1'b1, "R5 enable applied", v, 1);

        // disabled while dividing, R4
        n_code = 3'b001;
        repeat (40) @(posedge clk);
        out_en = 1'b0;
        repeat (2) @(posedge clk);
        errs = 0;
        for (int i = 0; i < 16; i++) begin
            at_pos(v); if (v !== 1'b0 || ch_comp !== '1) errs++;
            at_neg(v); if (v !== 1'b0) errs++;
        end
        chk(errs == 0, "R4 divided output stays off", errs, 0);
        out_en = 1'b1;

        // ---- reset mid-run and release, R6
        n_code = 3'b000;
        repeat (20) @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            at_pos(v);
            if (v == 1'b1) break;
        end
        rst = 1'b1;
        #1;
        chk(ch_true == '0 && ch_comp == '1, "R6 reset forces at once", int'(ch_true), 0);
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        rst = 1'b0;
        repeat (6) @(posedge clk);
        errs = 0;
        for (int i = 0; i < 8; i++) begin
            at_pos(ps[i]);
        end
        for (int i = 1; i < 8; i++) begin
            if (ps[i] == ps[i-1]) errs++;
        end
        chk(errs == 0, "R6 outputs resume after release", errs, 0);

        chk(chan_err == 0, "R9 channels equal and complementary", chan_err, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule